// File: doc/BRIEF.md
# Processor Clock Generator with Free-Running Timer

This block drives the processor's clock from a fast reference clock. It produces a one-cycle enable pulse, `cpu_en`, in the reference clock domain. The processor's registers advance only on reference edges where `cpu_en` is high. In automatic mode the pulse rate is the reference rate divided by a selectable power of two. The rate comes from a tap on a binary counter. With a 2^22 Hz reference and a 24-bit divider, the slowest setting is 0.25 Hz. In manual mode, each debounced press of a step button gives exactly one pulse. A halt request from the control logic blocks pulses in both modes.

The divider counter is 32 bits wide and never stops. It is also the processor's timer. The processor reads the timer as two 16-bit halves. Reading the low half captures the high half at the same instant, so a later read of the high half returns a value consistent with the low half, even if a carry into the high half happened between the two reads. At a 2^22 Hz reference, the timer wraps after about 17 minutes.

Top module: `clkgen_timer`

## Requirements
- R1: After a synchronous reset, `cpu_en`, `tmr_lo`, `tmr_hi` and the internal counter are all zero.
- R2: The counter increments by one on every reference edge after reset. It keeps counting whatever the mode, tap, button or halt inputs do.
- R3: In automatic mode with tap k (k ≤ DIV_W) and no halt, `cpu_en` is a single-cycle pulse. It appears on the edge after the counter's low k bits were all ones, giving a period of exactly 2^k reference cycles. For k = 0 the pulse is high on every cycle.
- R4: A tap value greater than DIV_W behaves as DIV_W, the slowest rate.
- R5: In manual mode, one rising edge of `step_btn` held longer than 2^DEB_W cycles gives exactly one pulse. The pulse appears on the (2^DEB_W+3)-th reference edge, counting the first edge that samples the new level as edge one.
- R6: A button level held for fewer than 2^DEB_W cycles gives no pulse, and releasing the button gives no pulse.
- R7: When `halt` is sampled high, `cpu_en` is low on the following cycle in either mode. A press that completes while halted is lost.
- R8: In automatic mode the button has no effect on the pulse train. In manual mode the divider produces no pulses.
- R9: When `rd_lo` is sampled high, `tmr_lo` takes bits 15:0 of the counter value at that edge, and bits 31:16 of the same value are captured internally.
- R10: When `rd_hi` is sampled high, `tmr_hi` takes the high half captured by the last `rd_lo`, not the live counter.
- R11: `tmr_lo` and `tmr_hi` keep their value on every edge where their own read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = automatic divided clock, 0 = manual single step |
| tap_sel | input | TAP_W | Divider tap k; the automatic period is 2^k reference cycles |
| step_btn | input | 1 | Raw, possibly bouncing step button level |
| halt | input | 1 | Halt request from control logic |
| rd_lo | input | 1 | Read low timer half and capture the high half |
| rd_hi | input | 1 | Read the captured high timer half |
| cpu_en | output | 1 | Registered processor clock enable pulse |
| tmr_lo | output | CNT_W/2 | Low timer half from the last low read |
| tmr_hi | output | CNT_W/2 | High timer half captured with the last low read |

## Verification
The checker watches several properties on every cycle:
- halt suppresses the next pulse;
- both timer words hold between their reads;
- a low read returns the low half of an independently kept cycle count;
- tap zero gives a pulse on every cycle;
- no manual pulse appears unless the button has been quiet for the debounce interval.

Some behaviours are visible only in the bench's timed scenarios:
- the exact pulse spacing for several taps, including the clamp above DIV_W;
- the exact delay from a press to its pulse;
- the absence of pulses for short bounces, for releases, for presses during halt and for presses in automatic mode;
- the consistency of the two timer halves across a carry into bit 16.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic {
    STEP_MANUAL = 1'b0,
    STEP_AUTO   = 1'b1
  } step_mode_e;
endpackage

// File: rtl/clkgen_divider.sv
// Free-running counter; tick marks the last cycle of each 2^k period.
module clkgen_divider #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 24,
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] tap_sel,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  logic [DIV_W-1:0] watch;

  // Bit i takes part in the compare when i < k; larger k saturates at DIV_W.
  for (genvar i = 0; i < DIV_W; i++) begin : g_watch
    assign watch[i] = (32'(tap_sel) > 32'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  assign tick = &(count[DIV_W-1:0] | ~watch);
endmodule

// File: rtl/clkgen_debounce.sv
// Two-flop synchronizer, dwell counter and rising-edge detect.
module clkgen_debounce #(
  parameter int DEB_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic press
);
  localparam logic [DEB_W-1:0] DWELL_MAX = '1;

  logic [1:0]       sync;
  logic             level;
  logic             level_d;
  logic [DEB_W-1:0] dwell;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= '0;
      level   <= 1'b0;
      level_d <= 1'b0;
      dwell   <= '0;
    end else begin
      sync    <= {sync[0], btn};
      level_d <= level;
      if (sync[1] != level) begin
        if (dwell == DWELL_MAX) begin
          level <= sync[1];
          dwell <= '0;
        end else begin
          dwell <= dwell + 1'b1;
        end
      end else begin
        dwell <= '0;
      end
    end
  end

  assign press = level & ~level_d;
endmodule

// File: rtl/clkgen_rdport.sv
// Split read of the counter; the high half is captured with the low read.
module clkgen_rdport #(
  parameter int CNT_W  = 32,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [HALF_W-1:0] word_lo,
  output logic [HALF_W-1:0] word_hi
);
  logic [HALF_W-1:0] held_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_lo <= '0;
      word_hi <= '0;
      held_hi <= '0;
    end else begin
      if (rd_lo) begin
        word_lo <= count[HALF_W-1:0];
        held_hi <= count[CNT_W-1:HALF_W];
      end
      if (rd_hi) word_hi <= held_hi;
    end
  end
endmodule

// File: rtl/clkgen_timer.sv
module clkgen_timer
  import clkgen_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 24,
  parameter int TAP_W = 5,
  parameter int DEB_W = 16,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              auto_mode,
  input  logic [TAP_W-1:0]  tap_sel,
  input  logic              step_btn,
  input  logic              halt,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic              cpu_en,
  output logic [HALF_W-1:0] tmr_lo,
  output logic [HALF_W-1:0] tmr_hi
);
  step_mode_e       mode;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             press;

  assign mode = step_mode_e'(auto_mode);

  clkgen_divider #(.CNT_W(CNT_W), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_div (
    .clk(clk_ref), .rst(rst), .tap_sel(tap_sel), .count(count), .tick(tick)
  );

  clkgen_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk(clk_ref), .rst(rst), .btn(step_btn), .press(press)
  );

  clkgen_rdport #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_rd (
    .clk(clk_ref), .rst(rst), .count(count), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .word_lo(tmr_lo), .word_hi(tmr_hi)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) cpu_en <= 1'b0;
    else     cpu_en <= !halt && ((mode == STEP_AUTO) ? tick : press);
  end
endmodule

// File: rtl/clkgen_timer_chk.sv
module clkgen_timer_chk #(
  parameter int CNT_W = 32,
  parameter int TAP_W = 5,
  parameter int DEB_W = 16,
  parameter int HALF_W = CNT_W / 2
) (
  input logic              clk_ref,
  input logic              rst,
  input logic              auto_mode,
  input logic [TAP_W-1:0]  tap_sel,
  input logic              step_btn,
  input logic              halt,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              cpu_en,
  input logic [HALF_W-1:0] tmr_lo,
  input logic [HALF_W-1:0] tmr_hi
);
  localparam int QW = DEB_W + 2;
  localparam logic [QW-1:0] DEB_LEN = QW'(1) << DEB_W;

  logic [CNT_W-1:0] ref_cnt;
  logic [QW-1:0]    quiet;
  logic             btn_q;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      ref_cnt <= '0;
      quiet   <= '0;
      btn_q   <= 1'b0;
    end else begin
      ref_cnt <= ref_cnt + 1'b1;
      btn_q   <= step_btn;
      if (step_btn != btn_q) quiet <= '0;
      else if (quiet != '1)  quiet <= quiet + 1'b1;
    end
  end

  // R7
  halt_blocks_chk: assert property (@(posedge clk_ref) disable iff (rst)
    halt |=> !cpu_en);

  // R11
  lo_hold_chk: assert property (@(posedge clk_ref) disable iff (rst)
    !rd_lo |=> $stable(tmr_lo));

  // R11
  hi_hold_chk: assert property (@(posedge clk_ref) disable iff (rst)
    !rd_hi |=> $stable(tmr_hi));

  // R3
  tap_zero_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (auto_mode && tap_sel == '0 && !halt) |=> cpu_en);

  // R9
  lo_capture_chk: assert property (@(posedge clk_ref) disable iff (rst)
    rd_lo |=> (tmr_lo == $past(ref_cnt[HALF_W-1:0])));

  // R6
  debounce_quiet_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (cpu_en && !$past(auto_mode)) |-> (quiet >= DEB_LEN));
endmodule

bind clkgen_timer clkgen_timer_chk #(
  .CNT_W(CNT_W), .TAP_W(TAP_W), .DEB_W(DEB_W), .HALF_W(HALF_W)
) u_chk (
  .clk_ref(clk_ref), .rst(rst), .auto_mode(auto_mode), .tap_sel(tap_sel),
  .step_btn(step_btn), .halt(halt), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .cpu_en(cpu_en), .tmr_lo(tmr_lo), .tmr_hi(tmr_hi)
);

// File: tb/clkgen_timer_bench.sv
module clkgen_timer_bench;
  localparam int CNT_W   = 32;
  localparam int DIV_W   = 4;
  localparam int TAP_W   = 5;
  localparam int DEB_W   = 4;
  localparam int DEB_LEN = 1 << DEB_W;
  localparam int HALF_W  = CNT_W / 2;

  logic              clk_ref = 1'b0;
  logic              rst = 1'b1;
  logic              auto_mode = 1'b0;
  logic [TAP_W-1:0]  tap_sel = '0;
  logic              step_btn = 1'b0;
  logic              halt = 1'b0;
  logic              rd_lo = 1'b0;
  logic              rd_hi = 1'b0;
  logic              cpu_en;
  logic [HALF_W-1:0] tmr_lo;
  logic [HALF_W-1:0] tmr_hi;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  string quiet_tag = "R1";
  bit    done = 1'b0;
  int    hi_model = 0;

  clkgen_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W), .TAP_W(TAP_W), .DEB_W(DEB_W)) u_clkgen_timer (
    .clk_ref(clk_ref), .rst(rst), .auto_mode(auto_mode), .tap_sel(tap_sel),
    .step_btn(step_btn), .halt(halt), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .cpu_en(cpu_en), .tmr_lo(tmr_lo), .tmr_hi(tmr_hi)
  );

  always #10 clk_ref = ~clk_ref;

  // Cycle model of R2: edges since reset equal the counter value.
  always @(posedge clk_ref) cyc <= rst ? 0 : cyc + 1;

  task automatic fail(string tag, string what, longint act, longint exp);
    errors++;
    checks++;
    $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic check(string tag, string what, longint act, longint exp);
    if (act != exp) fail(tag, what, act, exp);
    else checks++;
  endtask

  // Monitor: pops expected pulse cycles and compares them with cpu_en.
  always @(negedge clk_ref) begin
    if (!rst && !done) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        fail(tag_q[0], "missing pulse at cycle", -1, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (cpu_en) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          checks++;
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else begin
          fail(quiet_tag, "unexpected pulse at cycle", cyc,
               (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  // R3 / R4 / R8: automatic pulses every 2^min(k,DIV_W) cycles.
  task automatic run_auto(int k, int len, logic btn, string tag);
    int kk = (k > DIV_W) ? DIV_W : k;
    int per = 1 << kk;
    auto_mode = 1'b1; tap_sel = TAP_W'(k); halt = 1'b0; step_btn = btn;
    quiet_tag = tag;
    for (int n = cyc + 1; n <= cyc + len; n++) begin
      if (n % per == 0) begin exp_q.push_back(n); tag_q.push_back(tag); end
    end
    repeat (len) @(negedge clk_ref);
  endtask

  // R7: halted automatic mode at the fastest tap.
  task automatic run_halt(int len);
    auto_mode = 1'b1; tap_sel = '0; halt = 1'b1; quiet_tag = "R7";
    repeat (len) @(negedge clk_ref);
  endtask

  // R5 / R7: one manual press, then release.
  task automatic press(logic hlt, int hold, string tag);
    auto_mode = 1'b0; halt = hlt; step_btn = 1'b1; quiet_tag = tag;
    if (!hlt) begin exp_q.push_back(cyc + DEB_LEN + 3); tag_q.push_back(tag); end
    repeat (hold) @(negedge clk_ref);
    step_btn = 1'b0;
    quiet_tag = "R6";
    repeat (DEB_LEN + 10) @(negedge clk_ref);
  endtask

  // R6: short bounces produce nothing.
  task automatic bounce();
    auto_mode = 1'b0; halt = 1'b0; quiet_tag = "R6";
    step_btn = 1'b1; repeat (6) @(negedge clk_ref);
    step_btn = 1'b0; repeat (6) @(negedge clk_ref);
    step_btn = 1'b1; repeat (DEB_LEN - 6) @(negedge clk_ref);
    step_btn = 1'b0; repeat (DEB_LEN + 10) @(negedge clk_ref);
  endtask

  task automatic read_lo(string tag);
    int c = cyc;
    rd_lo = 1'b1;
    @(negedge clk_ref);
    rd_lo = 1'b0;
    check(tag, "timer low half", tmr_lo, c & 16'hFFFF);
    hi_model = c >>> 16;
  endtask

  task automatic read_hi(string tag, int exp);
    rd_hi = 1'b1;
    @(negedge clk_ref);
    rd_hi = 1'b0;
    check(tag, "timer high half", tmr_hi, exp);
  endtask

  initial begin
    logic [HALF_W-1:0] kept;
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref);
    rst = 1'b0;
    @(negedge clk_ref);
    // R1 reset state
    check("R1", "cpu_en after reset", cpu_en, 0);
    check("R1", "tmr_lo after reset", tmr_lo, 0);
    check("R1", "tmr_hi after reset", tmr_hi, 0);

    run_auto(0, 12, 1'b0, "R3");
    run_auto(1, 20, 1'b0, "R3");
    run_auto(3, 40, 1'b0, "R3");
    run_auto(4, 50, 1'b0, "R3");
    run_auto(7, 50, 1'b0, "R4");
    run_halt(30);
    run_auto(2, 40, 1'b1, "R8");
    run_auto(2, 40, 1'b0, "R8");
    press(1'b0, DEB_LEN + 8, "R5");
    press(1'b0, DEB_LEN + 30, "R5");
    bounce();
    press(1'b1, DEB_LEN + 8, "R7");

    // R9 / R11: capture then hold
    halt = 1'b0; auto_mode = 1'b0; quiet_tag = "R8";
    read_lo("R9");
    kept = tmr_lo;
    repeat (7) @(negedge clk_ref);
    check("R11", "tmr_lo held without read", tmr_lo, kept);
    read_hi("R10", hi_model);
    check("R11", "tmr_lo held across high read", tmr_lo, kept);

    // R2: timer runs on through halt up to the carry into the high half
    halt = 1'b1; quiet_tag = "R7";
    while (cyc != 65534) @(negedge clk_ref);
    read_lo("R2");
    check("R9", "captured high before carry", hi_model, 0);
    repeat (6) @(negedge clk_ref);
    read_hi("R10", 0);
    read_lo("R9");
    check("R2", "captured high after carry", hi_model, 1);
    read_hi("R10", 1);

    repeat (4) @(negedge clk_ref);
    while (exp_q.size() > 0) begin
      fail(tag_q[0], "pulse never seen", -1, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      done = 1'b1;
      fail("R2", "watchdog expired at cycle", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule